// File: doc/BRIEF.md
# Six-bit table-function ALU slice

This block is one slice of a bit-sliced arithmetic unit. Each slice sees a 6-bit left operand, a 6-bit right operand and a 6-bit operation code. From that 18-bit input it forms a 6-bit result and three side bits: a carry/borrow bit and two compare flags. The slice acts like a lookup table addressed by all 18 input bits. Here it is built as combinational logic followed by one output register.

The operation space has five groups. The first sixteen codes hold every two-input Boolean function, with the low code bits used as the truth table. The next group is arithmetic: add, subtract, the two halves of a 6x6 product, compare, minimum and maximum. After that come operations that stay inside the slice: population count, shifts and rotates confined to the six bits, a fixed permutation used by a wide-word rotate and its inverse, and a small fixed substitution box. All remaining codes return zero.

Wider words are formed by placing several slices side by side and combining their results outside this block.

Top module: `alu6_slice`

## Requirements
- R1: All outputs are registered. A result appears on the rising edge after its inputs are sampled and stays steady until the next edge. While the synchronous active-low reset is low, the outputs clear to zero.
- R2: For codes 0x00 to 0x0F, each result bit i equals bit `{left[i], right[i]}` of the 4-bit code. So 0x8 is AND, 0xE is OR, 0x6 is XOR, 0x0 gives all zeros and 0xF gives all ones.
- R3: Code 0x10 returns (left + right) mod 64, with the carry bit set when the sum exceeds 63. Only codes 0x10 and 0x11 may set the carry bit.
- R4: Code 0x11 returns (left - right) mod 64, with the carry bit set as a borrow when left < right.
- R5: Code 0x12 returns the low six bits of left*right. Code 0x13 returns the high six bits.
- R6: Code 0x14 returns a zero result, sets the less-than flag when left < right, and sets the equal flag when left == right. Both flags are zero for every other code.
- R7: Code 0x15 returns the unsigned minimum of the operands. Code 0x16 returns the unsigned maximum.
- R8: Code 0x17 returns the number of set bits in left, zero-extended. The right operand has no effect.
- R9: Code 0x18 shifts left logically, and code 0x19 shifts right logically. The shift amount is right[2:0]. An amount of 6 or 7 gives zero.
- R10: Code 0x1A rotates left within the six bits, and code 0x1B rotates right. The amount is right[2:0] modulo 6.
- R11: Code 0x1C returns `{l5,l2,l3,l0,l1,l4}` (MSB first), which is the fix-up step of a wide rotate-left-by-one. Code 0x1D returns `{l5,l0,l3,l4,l1,l2}`, the inverse permutation.
- R12: Code 0x1E returns ((left XOR 0x2A) * 37 + 11) mod 64.
- R13: Codes 0x1F to 0x3F return zero on all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 6 | Operation code |
| left_i | input | 6 | Left operand |
| right_i | input | 6 | Right operand |
| result_o | output | 6 | Registered 6-bit result |
| carry_o | output | 1 | Carry for add, borrow for subtract |
| lt_o | output | 1 | Compare: left below right |
| eq_o | output | 1 | Compare: operands equal |

## Verification
The properties assume that the operation code and operands are known values at every clock edge once reset is released, and that they are held across each edge. Every property that looks back one cycle compares the output with the inputs sampled at the previous edge. The bench therefore changes inputs only on the falling edge and reads the outputs one full cycle later, also on a falling edge. A checker flag keeps those look-back properties quiet until one edge has passed out of reset, so the reset value is never matched against operands driven during reset.

// File: rtl/alu6_pkg.sv
// Package: shared widths, opcode assignment and constants for the 6-bit
// function-table ALU slice. The opcode numbering is behaviour: the Boolean
// group uses the low four code bits as its truth table.
package alu6_pkg;

    localparam int W    = 6;                 // slice width
    localparam int OPW  = 6;                 // opcode width
    localparam int SHW  = $clog2(W + 1);     // shift amount width
    localparam int PW   = 2 * W;             // full product width

    // substitution box constants: y = ((x ^ KEY) * MUL + ADD) mod 2^W
    localparam logic [W-1:0] SBOX_KEY = 6'h2A;
    localparam logic [W-1:0] SBOX_MUL = 6'd37;
    localparam logic [W-1:0] SBOX_ADD = 6'd11;

    typedef enum logic [OPW-1:0] {
        OP_FALSE   = 6'h00,
        OP_NOR     = 6'h01,
        OP_RANDNL  = 6'h02,
        OP_NOTL    = 6'h03,
        OP_LANDNR  = 6'h04,
        OP_NOTR    = 6'h05,
        OP_XOR     = 6'h06,
        OP_NAND    = 6'h07,
        OP_AND     = 6'h08,
        OP_XNOR    = 6'h09,
        OP_PASSR   = 6'h0A,
        OP_RORNL   = 6'h0B,
        OP_PASSL   = 6'h0C,
        OP_LORNR   = 6'h0D,
        OP_OR      = 6'h0E,
        OP_TRUE    = 6'h0F,
        OP_ADD     = 6'h10,
        OP_SUB     = 6'h11,
        OP_MULLO   = 6'h12,
        OP_MULHI   = 6'h13,
        OP_CMP     = 6'h14,
        OP_MIN     = 6'h15,
        OP_MAX     = 6'h16,
        OP_POPCNT  = 6'h17,
        OP_SHL     = 6'h18,
        OP_SHR     = 6'h19,
        OP_ROTL    = 6'h1A,
        OP_ROTR    = 6'h1B,
        OP_PERM    = 6'h1C,
        OP_PERMINV = 6'h1D,
        OP_SBOX    = 6'h1E
    } opcode_e;

    typedef struct packed {
        logic [W-1:0] res;
        logic         carry;
        logic         lt;
        logic         eq;
    } slice_out_t;

endpackage

// File: rtl/alu6_bool.sv
// Module: alu6_bool
// Applies one of the sixteen two-input Boolean functions bitwise. The 4-bit
// truth table selects the output for each (left bit, right bit) pair, with
// the left bit as the index MSB. Assumes nothing about the operands.
module alu6_bool
    import alu6_pkg::*;
(
    input  logic [3:0]   tt_i,
    input  logic [W-1:0] left_i,
    input  logic [W-1:0] right_i,
    output logic [W-1:0] res_o
);

    // one truth-table lookup per bit position
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign res_o[i] = tt_i[{left_i[i], right_i[i]}];
    end

endmodule

// File: rtl/alu6_arith.sv
// Module: alu6_arith
// Arithmetic group: add and subtract with carry/borrow, the two product
// halves, compare flags, minimum and maximum. Raises hit_o when the code
// belongs to this group; all outputs are zero otherwise.
module alu6_arith
    import alu6_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   left_i,
    input  logic [W-1:0]   right_i,
    output slice_out_t     out_o,
    output logic           hit_o
);

    logic [W:0]    sum;
    logic [W:0]    diff;
    logic [PW-1:0] prod;
    logic          below;

    // shared adders, subtractor and multiplier
    always_comb begin
        sum   = {1'b0, left_i} + {1'b0, right_i};
        diff  = {1'b0, left_i} - {1'b0, right_i};
        prod  = PW'(left_i) * PW'(right_i);
        below = diff[W];
    end

    // pick the group member named by the code
    always_comb begin
        out_o = '0;
        hit_o = 1'b1;
        case (op_i)
            OP_ADD: begin
                out_o.res   = sum[W-1:0];
                out_o.carry = sum[W];
            end
            OP_SUB: begin
                out_o.res   = diff[W-1:0];
                out_o.carry = below;
            end
            OP_MULLO: out_o.res = prod[W-1:0];
            OP_MULHI: out_o.res = prod[PW-1:W];
            OP_CMP: begin
                out_o.lt = below;
                out_o.eq = (left_i == right_i);
            end
            OP_MIN:  out_o.res = below ? left_i  : right_i;
            OP_MAX:  out_o.res = below ? right_i : left_i;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu6_shuffle.sv
// Module: alu6_shuffle
// Operations on the left operand alone that stay inside the slice:
// population count, logical shifts, rotates, the wide-rotate permutation
// and its inverse, and the fixed substitution box. Only the amount bits of
// the right operand reach this module. Assumes W = 6 for the permutations.
module alu6_shuffle
    import alu6_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   left_i,
    input  logic [SHW-1:0] amt_i,
    output logic [W-1:0]   res_o,
    output logic           hit_o
);

    localparam logic [SHW-1:0] AMT_W = SHW'(W);

    logic [W-1:0]   ones;
    logic [SHW-1:0] rot_amt;
    logic [PW-1:0]  dbl_l;
    logic [PW-1:0]  dbl_r;
    logic [W-1:0]   shl;
    logic [W-1:0]   shr;
    logic [W-1:0]   perm;
    logic [W-1:0]   perm_inv;
    logic [W-1:0]   sbox;

    // count set bits of the left operand
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + W'(left_i[i]);
        end
    end

    // shifts saturate to zero; rotate amount folds modulo the width
    always_comb begin
        shl     = (amt_i >= AMT_W) ? '0 : (left_i << amt_i);
        shr     = (amt_i >= AMT_W) ? '0 : (left_i >> amt_i);
        rot_amt = (amt_i >= AMT_W) ? (amt_i - AMT_W) : amt_i;
        dbl_l   = {left_i, left_i} << rot_amt;
        dbl_r   = {left_i, left_i} >> rot_amt;
    end

    // fixed wiring permutations and substitution box
    always_comb begin
        perm     = {left_i[5], left_i[2], left_i[3], left_i[0], left_i[1], left_i[4]};
        perm_inv = {left_i[5], left_i[0], left_i[3], left_i[4], left_i[1], left_i[2]};
        sbox     = W'((left_i ^ SBOX_KEY) * SBOX_MUL + SBOX_ADD);
    end

    // select by code
    always_comb begin
        hit_o = 1'b1;
        case (op_i)
            OP_POPCNT:  res_o = ones;
            OP_SHL:     res_o = shl;
            OP_SHR:     res_o = shr;
            OP_ROTL:    res_o = dbl_l[PW-1:W];
            OP_ROTR:    res_o = dbl_r[W-1:0];
            OP_PERM:    res_o = perm;
            OP_PERMINV: res_o = perm_inv;
            OP_SBOX:    res_o = sbox;
            default: begin
                res_o = '0;
                hit_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu6_slice.sv
// Module: alu6_slice (top)
// One 6-bit slice of a sliced ALU. Three function units evaluate in
// parallel, and a priority select picks one by opcode group. The chosen
// result and flags are registered once. Unassigned codes produce zero.
// Assumes inputs are stable around the rising clock edge.
module alu6_slice
    import alu6_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   left_i,
    input  logic [W-1:0]   right_i,
    output logic [W-1:0]   result_o,
    output logic           carry_o,
    output logic           lt_o,
    output logic           eq_o
);

    logic [W-1:0] bool_res;
    slice_out_t   arith_out;
    logic         arith_hit;
    logic [W-1:0] shuf_res;
    logic         shuf_hit;
    logic         is_bool;
    slice_out_t   nxt;
    slice_out_t   q;

    alu6_bool u_bool (
        .tt_i    (op_i[3:0]),
        .left_i  (left_i),
        .right_i (right_i),
        .res_o   (bool_res)
    );

    alu6_arith u_arith (
        .op_i    (op_i),
        .left_i  (left_i),
        .right_i (right_i),
        .out_o   (arith_out),
        .hit_o   (arith_hit)
    );

    alu6_shuffle u_shuffle (
        .op_i    (op_i),
        .left_i  (left_i),
        .amt_i   (right_i[SHW-1:0]),
        .res_o   (shuf_res),
        .hit_o   (shuf_hit)
    );

    // Boolean group occupies the lowest sixteen codes
    assign is_bool = (op_i[OPW-1:4] == '0);

    // group select, zero for unassigned codes
    always_comb begin
        nxt = '0;
        if (is_bool) begin
            nxt.res = bool_res;
        end else if (arith_hit) begin
            nxt = arith_out;
        end else if (shuf_hit) begin
            nxt.res = shuf_res;
        end
    end

    // output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    assign result_o = q.res;
    assign carry_o  = q.carry;
    assign lt_o     = q.lt;
    assign eq_o     = q.eq;

endmodule

// File: rtl/alu6_slice_chk.sv
// Module: alu6_slice_chk
// Property checker bound to alu6_slice. Look-back properties relate the
// registered outputs to the inputs of the previous edge. They are enabled
// only once a full edge has passed out of reset.
module alu6_slice_chk
    import alu6_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] op_i,
    input logic [W-1:0]   left_i,
    input logic [W-1:0]   right_i,
    input logic [W-1:0]   result_o,
    input logic           carry_o,
    input logic           lt_o,
    input logic           eq_o
);

    logic armed;

    // set after the first edge with reset released
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !carry_o && !lt_o && !eq_o));

    p_true_all_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_TRUE) |-> (result_o == '1));

    p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_ADD) |->
        (carry_o == (({1'b0, $past(left_i)} + {1'b0, $past(right_i)}) > 7'd63)));

    p_carry_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) != OP_ADD && $past(op_i) != OP_SUB) |-> !carry_o);

    p_sub_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_SUB) |-> (carry_o == ($past(left_i) < $past(right_i))));

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lt_o && eq_o));

    p_flags_cmp_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) != OP_CMP) |-> (!lt_o && !eq_o));

    p_popcnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_POPCNT) |-> (result_o <= 6'd6));

    p_unused_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) >= 6'h1F) |-> (result_o == '0 && !carry_o));

endmodule

bind alu6_slice alu6_slice_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .left_i   (left_i),
    .right_i  (right_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .lt_o     (lt_o),
    .eq_o     (eq_o)
);

// File: tb/alu6_slice_tb.sv
// Directed bench for alu6_slice: one task per scenario, each checking its
// results against a model written from the requirements.
module alu6_slice_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op = '0;
    logic [5:0] lft = '0;
    logic [5:0] rgt = '0;
    logic [5:0] result;
    logic       carry, lt, eq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alu6_slice u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .left_i(lft), .right_i(rgt),
        .result_o(result), .carry_o(carry), .lt_o(lt), .eq_o(eq)
    );

    function automatic logic [8:0] model(int o, int l, int r);
        int res = 0, c = 0, f_lt = 0, f_eq = 0, a;
        if (o < 16) begin
            for (int i = 0; i < 6; i++) begin
                int idx = ((l >> i) & 1) * 2 + ((r >> i) & 1);
                res |= ((o >> idx) & 1) << i;
            end
        end else begin
            case (o)
                16: begin res = (l + r) & 63; c = (l + r) > 63; end
                17: begin res = (l - r) & 63; c = (l < r); end
                18: res = (l * r) & 63;
                19: res = (l * r) >> 6;
                20: begin f_lt = (l < r); f_eq = (l == r); end
                21: res = (l < r) ? l : r;
                22: res = (l < r) ? r : l;
                23: for (int i = 0; i < 6; i++) res += (l >> i) & 1;
                24: begin a = r & 7; res = (a >= 6) ? 0 : (l << a) & 63; end
                25: begin a = r & 7; res = (a >= 6) ? 0 : (l >> a); end
                26: begin a = (r & 7) % 6; res = ((l << a) | (l >> (6 - a))) & 63; end
                27: begin a = (r & 7) % 6; res = ((l >> a) | (l << (6 - a))) & 63; end
                28: res = (((l>>5)&1)<<5) | (((l>>2)&1)<<4) | (((l>>3)&1)<<3)
                        | (((l>>0)&1)<<2) | (((l>>1)&1)<<1) | ((l>>4)&1);
                29: res = (((l>>5)&1)<<5) | (((l>>0)&1)<<4) | (((l>>3)&1)<<3)
                        | (((l>>4)&1)<<2) | (((l>>1)&1)<<1) | ((l>>2)&1);
                30: res = (((l ^ 42) * 37) + 11) & 63;
                default: res = 0;
            endcase
        end
        return {res[5:0], c[0], f_lt[0], f_eq[0]};
    endfunction

    task automatic check(string tag, logic [8:0] got, logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got res=%0d c=%0b lt=%0b eq=%0b, expected res=%0d c=%0b lt=%0b eq=%0b",
                     tag, got[8:3], got[2], got[1], got[0], exp[8:3], exp[2], exp[1], exp[0]);
        end
    endtask

    // drive on falling edge, read one cycle later on falling edge
    task automatic run(string tag, int o, int l, int r);
        @(negedge clk);
        op = 6'(o); lft = 6'(l); rgt = 6'(r);
        @(negedge clk);
        check(tag, {result, carry, lt, eq}, model(o, l, r));
    endtask

    task automatic t_reset();
        @(negedge clk);
        op = 6'h10; lft = 6'd63; rgt = 6'd63;
        @(negedge clk);
        check("R1 reset clear", {result, carry, lt, eq}, 9'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        run("R1 first value", 16, 5, 7);
        @(negedge clk);
        op = 6'h12; lft = 6'd9; rgt = 6'd9;
        #2;
        check("R1 hold before edge", {result, carry, lt, eq}, model(16, 5, 7));
        @(negedge clk);
        check("R1 update after edge", {result, carry, lt, eq}, model(18, 9, 9));
    endtask

    task automatic t_bool();
        for (int o = 0; o < 16; o++) begin
            run("R2 bool", o, 6'b110010, 6'b101001);
            run("R2 bool", o, 0, 63);
        end
    endtask

    task automatic t_add_sub();
        run("R3 add no carry", 16, 20, 30);
        run("R3 add carry", 16, 40, 30);
        run("R3 add max", 16, 63, 63);
        run("R3 add edge", 16, 63, 0);
        run("R4 sub plain", 17, 30, 20);
        run("R4 sub borrow", 17, 20, 30);
        run("R4 sub equal", 17, 33, 33);
    endtask

    task automatic t_mul();
        run("R5 mul lo", 18, 63, 63);
        run("R5 mul hi", 19, 63, 63);
        run("R5 mul hi", 19, 13, 11);
        run("R5 mul lo", 18, 13, 11);
    endtask

    task automatic t_cmp();
        run("R6 cmp less", 20, 3, 40);
        run("R6 cmp equal", 20, 17, 17);
        run("R6 cmp greater", 20, 50, 1);
        run("R7 min", 21, 50, 1);
        run("R7 max", 22, 50, 1);
        run("R7 min eq", 21, 9, 9);
        run("R7 max", 22, 2, 61);
    endtask

    task automatic t_popcnt();
        run("R8 popcount all", 23, 63, 0);
        run("R8 popcount right ignored", 23, 6'b101100, 63);
        run("R8 popcount zero", 23, 0, 21);
    endtask

    task automatic t_shift();
        for (int a = 0; a < 8; a++) begin
            run("R9 shl", 24, 6'b101101, a);
            run("R9 shr", 25, 6'b101101, a + 8);
        end
    endtask

    task automatic t_rotate();
        for (int a = 0; a < 8; a++) begin
            run("R10 rotl", 26, 6'b100110, a);
            run("R10 rotr", 27, 6'b100110, a);
        end
    endtask

    task automatic t_perm();
        run("R11 perm", 28, 6'b100000, 0);
        run("R11 perm", 28, 6'b010000, 0);
        run("R11 perm", 28, 6'b000001, 0);
        run("R11 perm", 28, 6'b110101, 0);
        run("R11 perm inverse", 29, 6'b000100, 0);
        run("R11 perm inverse", 29, 6'b011010, 0);
    endtask

    task automatic t_sbox();
        run("R12 sbox", 30, 0, 0);
        run("R12 sbox", 30, 42, 5);
        run("R12 sbox", 30, 63, 0);
        run("R12 sbox", 30, 17, 0);
    endtask

    task automatic t_unused();
        for (int o = 31; o < 64; o += 4) run("R13 unused zero", o, 63, 63);
        run("R13 unused zero", 63, 40, 2);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_bool();
        t_add_sub();
        t_mul();
        t_cmp();
        t_popcnt();
        t_shift();
        t_rotate();
        t_perm();
        t_sbox();
        t_unused();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule